// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an asynchronous static RAM. It takes one single-word request at a time (read or write, address, write data) and produces the chip-select, output-enable and write-enable strobes for the memory. It also drives the memory address and the controller side of the data bus. When the transfer is complete it returns read data with a one-cycle completion pulse. The memory data bus appears as three separate signals: data towards the memory, an enable for the controller's drivers, and data coming back from the memory. The tristate buffer itself is left to the pad ring.

Every memory timing figure is a nanosecond parameter. Each one is turned into a whole number of system clock cycles at elaboration, rounding up. A grade parameter picks one of two default timing sets: a fast set built around an 8 ns cycle and a slow low-power set built around a 55 ns cycle. Individual figures can also be overridden. Because the counts are derived this way, the same code serves either part at any clock rate.

The host is told when a request can be taken through a ready output. While a transfer is in progress, a request is simply held off. All memory-side outputs come straight from flops.

Top module: `sram_ctrl`

## Requirements
- R1: During and after a synchronous reset, the outputs are: mem_cs_n, mem_oe_n and mem_we_n high; mem_dq_oe low; done low; ready high.
- R2: Whenever ready is high (no transfer in progress), mem_cs_n is high. Whenever mem_cs_n is high, mem_dq_oe is low.
- R3: A read holds mem_cs_n low, mem_oe_n low and mem_we_n high for exactly RD cycles. RD is the largest of ceil(tRC/Tclk), ceil(tAA/Tclk), ceil(tCO/Tclk) and ceil(tOE/Tclk). With the slow grade at a 20 ns clock, RD is 3.
- R4: On the last edge of the read interval, the value on mem_dq_i is captured into rdata. done is high for exactly the single cycle after that edge, and rdata is valid in that cycle.
- R5: A write holds mem_we_n low, with mem_cs_n low, for exactly WP cycles. WP is the largest of ceil(tWP/Tclk), ceil(tCW/Tclk) and ceil(tAW/Tclk). With the slow grade at 20 ns, WP is 3.
- R6: mem_oe_n stays high for the whole of a write transfer. mem_oe_n is never low while mem_we_n is low, so the memory and the controller never drive the bus at once.
- R7: mem_dq_oe is high in every cycle where mem_we_n is low, and in exactly one further cycle after mem_we_n rises. It is low otherwise.
- R8: A write transfer lasts WP + REC cycles, with mem_cs_n low throughout. REC is the largest of ceil(tWC/Tclk) − WP, ceil(tOW/Tclk) and 1. done pulses in the cycle after the last one. With the slow grade at 20 ns the total is 4.
- R9: While mem_cs_n is low, mem_addr and mem_dq_o hold the address and write data captured when the request was accepted.
- R10: A request is accepted on a clock edge where both req and ready are high. ready is low from acceptance until the transfer ends. While ready is low, req, we, addr and wdata have no effect on the strobes, the address or the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| ready | output | 1 | Controller idle, request can be taken |
| rdata | output | DATA_W | Read data, valid with done |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data driven towards the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_i | input | DATA_W | Data read back from the bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The assertions assume that reset is applied from time zero, and that a host keeps its request fields valid only for as long as it keeps req high. The bench makes no such promise while ready is low: it deliberately drives inverted operation, address and data during busy cycles, so the stall path is exercised. The strobe-width properties count cycles from the moment a strobe falls, so they presume each strobe starts high after reset, and the reset sequence guarantees this. The bench's memory model returns undefined data until the access time has passed and flags write pulses that are too short, which keeps the timing checks independent of the controller.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_WPULSE = 2'd2,
    ST_WREC   = 2'd3
  } seq_state_t;

  // ceiling of ns / period, never negative
  function automatic int ns_to_cyc(input int ns, input int period);
    if (ns <= 0) return 0;
    return (ns + period - 1) / period;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    return max2(max2(a, b), c);
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int RD_CYC  = 1,
  parameter int WP_CYC  = 1,
  parameter int REC_CYC = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             we,
  input  logic             last,
  output logic             accept,
  output logic             capture,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             ready,
  output logic             done,
  output logic             cs_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe
);
  seq_state_t state_q, state_d;

  assign ready   = (state_q == ST_IDLE);
  assign accept  = ready & req;
  assign capture = (state_q == ST_READ) & last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req)  state_d = we ? ST_WPULSE : ST_READ;
      ST_READ:   if (last) state_d = ST_IDLE;
      ST_WPULSE: if (last) state_d = ST_WREC;
      ST_WREC:   if (last) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = accept | ((state_q == ST_WPULSE) & last);
    if (accept) begin
      tmr_val = we ? CNT_W'(WP_CYC) : CNT_W'(RD_CYC);
    end else begin
      tmr_val = CNT_W'(REC_CYC);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cs_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_n    <= (state_d == ST_IDLE);
      oe_n    <= (state_d != ST_READ);
      we_n    <= (state_d != ST_WPULSE);
      dq_oe   <= (state_d == ST_WPULSE) |
                 ((state_q == ST_WPULSE) & (state_d == ST_WREC));
      done    <= (state_q != ST_IDLE) & (state_d == ST_IDLE);
    end
  end
endmodule

// File: rtl/sram_data_regs.sv
module sram_data_regs #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      mem_dq_o <= '0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        mem_addr <= addr;
        mem_dq_o <= wdata;
      end
      if (capture) begin
        rdata <= bus_in;
      end
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 20,
  parameter bit SLOW_GRADE = 1'b0,
  parameter int T_RC_NS    = SLOW_GRADE ? 55 : 8,
  parameter int T_AA_NS    = SLOW_GRADE ? 55 : 8,
  parameter int T_CO_NS    = SLOW_GRADE ? 55 : 8,
  parameter int T_OE_NS    = SLOW_GRADE ? 25 : 4,
  parameter int T_WC_NS    = SLOW_GRADE ? 55 : 8,
  parameter int T_CW_NS    = SLOW_GRADE ? 45 : 6,
  parameter int T_AW_NS    = SLOW_GRADE ? 45 : 6,
  parameter int T_WP_NS    = SLOW_GRADE ? 40 : 6,
  parameter int T_OW_NS    = SLOW_GRADE ? 5  : 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n
);
  localparam int RD_CYC  = max2(max3(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS),
                                     ns_to_cyc(T_CO_NS, CLK_NS)),
                                max2(ns_to_cyc(T_OE_NS, CLK_NS), 1));
  localparam int WP_CYC  = max2(max3(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_CW_NS, CLK_NS),
                                     ns_to_cyc(T_AW_NS, CLK_NS)), 1);
  localparam int REC_CYC = max3(ns_to_cyc(T_WC_NS, CLK_NS) - WP_CYC,
                                ns_to_cyc(T_OW_NS, CLK_NS), 1);
  localparam int MAX_CYC = max3(RD_CYC, WP_CYC, REC_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             accept;
  logic             capture;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_last;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  sram_seq_fsm #(
    .CNT_W   (CNT_W),
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .we       (we),
    .last     (tmr_last),
    .accept   (accept),
    .capture  (capture),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .ready    (ready),
    .done     (done),
    .cs_n     (mem_cs_n),
    .oe_n     (mem_oe_n),
    .we_n     (mem_we_n),
    .dq_oe    (mem_dq_oe)
  );

  sram_data_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .capture  (capture),
    .addr     (addr),
    .wdata    (wdata),
    .bus_in   (mem_dq_i),
    .mem_addr (mem_addr),
    .mem_dq_o (mem_dq_o),
    .rdata    (rdata)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int RD_CYC = 1,
  parameter int WP_CYC = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              ready,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n
);
  int unsigned oe_lo_cnt;
  int unsigned we_lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_lo_cnt <= 0;
      we_lo_cnt <= 0;
    end else begin
      oe_lo_cnt <= mem_oe_n ? 0 : oe_lo_cnt + 1;
      we_lo_cnt <= mem_we_n ? 0 : we_lo_cnt + 1;
    end
  end

  assert_idle_deselect_R2: assert property (@(posedge clk) disable iff (rst)
    ready |-> mem_cs_n);
  assert_standby_no_drive_R2: assert property (@(posedge clk) disable iff (rst)
    mem_cs_n |-> !mem_dq_oe);
  assert_read_width_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (oe_lo_cnt == RD_CYC));
  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_write_width_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_lo_cnt == WP_CYC));
  assert_oe_off_in_write_R6: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);
  assert_drive_in_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe);
  assert_drive_hold_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> mem_dq_oe);
  assert_bus_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !$past(mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));
  assert_accept_starts_R10: assert property (@(posedge clk) disable iff (rst)
    (req && ready) |=> !mem_cs_n);
endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .RD_CYC (RD_CYC),
  .WP_CYC (WP_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .ready     (ready),
  .done      (done),
  .mem_addr  (mem_addr),
  .mem_dq_o  (mem_dq_o),
  .mem_dq_oe (mem_dq_oe),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n)
);

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int TCK = 20;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // slow grade expectations at a 20 ns clock
  localparam int E_AA  = cdiv(55, TCK);
  localparam int E_RD  = mx(mx(cdiv(55, TCK), cdiv(55, TCK)), cdiv(25, TCK));
  localparam int E_WP  = mx(mx(cdiv(40, TCK), cdiv(45, TCK)), cdiv(45, TCK));
  localparam int E_REC = mx(mx(cdiv(55, TCK) - E_WP, cdiv(5, TCK)), 1);
  localparam int E_WR  = E_WP + E_REC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready, done, mem_dq_oe, mem_cs_n, mem_oe_n, mem_we_n;
  logic [DW-1:0] rdata, mem_dq_o, bus;
  logic [AW-1:0] mem_addr;

  always #(TCK/2) clk = ~clk;

  sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(TCK), .SLOW_GRADE(1'b1)) u_sram_ctrl (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .done(done), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(bus),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  int nchk = 0;
  int nfail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model with access delay and write-pulse checks
  logic [DW-1:0] mem [1<<AW];
  logic [DW-1:0] sb  [1<<AW];
  int rd_cnt = 0;
  int wl_cnt = 0;
  logic [DW-1:0] wl_data;
  logic [AW-1:0] wl_addr;
  logic model_drive;

  assign model_drive = !mem_cs_n && !mem_oe_n && mem_we_n && (rd_cnt >= E_AA);
  assign bus = model_drive ? mem[mem_addr] : (mem_dq_oe ? mem_dq_o : 'x);

  always @(negedge clk) begin
    if (rst) begin
      rd_cnt = 0;
      wl_cnt = 0;
    end else begin
      if (!mem_cs_n && !mem_oe_n && mem_we_n) rd_cnt++;
      else rd_cnt = 0;
      if (!mem_cs_n && !mem_we_n) begin
        wl_cnt++;
        wl_data = mem_dq_o;
        wl_addr = mem_addr;
        chk(mem_dq_oe && mem_oe_n, "R6 no bus contention in write", {mem_dq_oe, mem_oe_n}, 2'b11);
      end else if (wl_cnt != 0) begin
        chk(wl_cnt >= E_WP, "R5 write pulse long enough", wl_cnt, E_WP);
        mem[wl_addr] = wl_data;
        wl_cnt = 0;
      end
    end
  end

  task automatic do_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit noise);
    int n;
    logic [5:0] act, exp;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    while (!ready) @(negedge clk);
    @(posedge clk);
    n = w ? E_WR : E_RD;
    if (w) sb[a] = d;
    for (int k = 1; k <= n + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        if (noise) begin we = ~w; addr = ~a; wdata = ~d; end
        else req = 1'b0;
      end
      if (k == n) req = 1'b0;
      act = {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, ready, done};
      if (k <= n) begin
        if (w) begin
          exp = {1'b0, 1'b1, (k > E_WP), (k <= E_WP + 1), 1'b0, 1'b0};
          chk(act === exp, "R5 R6 R7 R8 R10 write strobes", act, exp);
          chk(mem_addr === a && mem_dq_o === d, "R9 write addr/data held",
              {mem_addr, mem_dq_o}, {a, d});
        end else begin
          exp = 6'b001000;
          chk(act === exp, "R3 R10 read strobes", act, exp);
          chk(mem_addr === a, "R9 read addr held", mem_addr, a);
        end
      end else begin
        exp = 6'b111011;
        chk(act === exp, "R4 R8 done after transfer", act, exp);
        if (!w) chk(rdata === sb[a], "R4 read data", rdata, sb[a]);
      end
    end
    req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [5:0] st;
    for (int i = 0; i < (1 << AW); i++) begin
      mem[i] = DW'(i * 37 + 11);
      sb[i]  = DW'(i * 37 + 11);
    end
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    st = {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, done, ready};
    chk(st === 6'b111001, "R1 reset state", st, 6'b111001);
    rst = 1'b0;
    @(negedge clk);
    st = {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, done, ready};
    chk(st === 6'b111001, "R1 state after reset", st, 6'b111001);

    do_op(1'b0, 6'd5, 8'h00, 1'b0);        // untouched word
    do_op(1'b1, 6'd0, 8'hA5, 1'b0);
    do_op(1'b0, 6'd0, 8'h00, 1'b0);
    do_op(1'b1, 6'd63, 8'h5A, 1'b1);       // busy-time noise, R10
    do_op(1'b0, 6'd63, 8'h00, 1'b1);
    do_op(1'b1, 6'd63, 8'hFF, 1'b0);       // back to back
    do_op(1'b1, 6'd62, 8'h00, 1'b0);
    do_op(1'b0, 6'd63, 8'h00, 1'b0);
    do_op(1'b0, 6'd62, 8'h00, 1'b0);

    for (int i = 0; i < 80; i++) begin
      do_op(1'($urandom_range(0, 1)), AW'($urandom), DW'($urandom), 1'($urandom_range(0, 1)));
    end

    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(mem_cs_n === 1'b1 && mem_dq_oe === 1'b0 && ready === 1'b1, "R2 idle deselected",
          {mem_cs_n, mem_dq_oe, ready}, 3'b101);
    end
    for (int i = 0; i < (1 << AW); i++) begin
      chk(mem[i] === sb[i], "R5 R8 memory contents", mem[i], sb[i]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule